// File: doc/BRIEF.md
# Serial port status flag controller

This block holds the four status flags of an asynchronous serial port: transmit data empty, receive data full, receive parity error and transmit end. The shift engines are not part of it. They report to it through single-cycle event inputs: a character received, with its data and parity bit; the transmit data taken into the shifter; and the last bit of a character sent. The block decides whether a received character is accepted and whether its parity is correct. It raises a strobe that loads the receive data register, and it holds reception halted while a parity error is pending.

Software reaches the flags through one status register port. A flag can only be cleared in two steps. Software must first read the register while the flag is 1, and later write 0 to that bit. A write of 1 is ignored. A write of 0 that was not preceded by such a read is also ignored. The transmit-end flag is read-only. It falls when software clears the transmit-empty flag in this two-step way, and it is forced high whenever the transmitter is disabled. Reset and standby return every flag to its initial value.

Status bit layout, used for both reads and writes: bit 0 is transmit empty, bit 1 is receive full, bit 2 is parity error and bit 3 is transmit end.

Top module: `uart_flag_ctrl`

## Requirements
- R1: On an accepted character, the parity error flag (bit 2) is set when the XOR of all data bits and the parity bit differs from the parity mode input (`odd_par_i` = 0 selects even parity, 1 selects odd parity).
- R2: The parity error flag clears only when software writes 0 to bit 2 after a read that saw bit 2 at 1. A write of 0 with no such read has no effect, and a write of 1 has no effect.
- R3: Dropping the receive enable leaves the parity error flag unchanged.
- R4: A character with a parity error pulses `rdr_load_o` in its event cycle but does not set the receive full flag (bit 1).
- R5: While the parity error flag is 1, `rx_halt_o` is 1 and a received character produces no load strobe and no change to the receive full flag.
- R6: Transmit end (bit 3) is set after a last-bit event only when transmit empty is 1 at that time. Otherwise it stays unchanged.
- R7: Transmit end clears together with a two-step clear of transmit empty (read with bit 0 at 1, then write 0 to bit 0).
- R8: Transmit end is 1 whenever the transmit enable is 0, and after standby.
- R9: Writes to bit 3 never change transmit end.
- R10: When a set event and a qualifying clear of the same flag fall in the same cycle, the flag ends up set.
- R11: After reset, transmit empty and transmit end are 1, and receive full and parity error are 0 (status reads 4'b1001).
- R12: A character received with correct parity while receive is enabled pulses `rdr_load_o` and sets receive full. With receive disabled, a character is neither loaded nor flagged.
- R13: Standby clears parity error and receive full and sets transmit empty and transmit end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Standby request, returns flags to initial values |
| te_i | input | 1 | Transmit enable |
| re_i | input | 1 | Receive enable |
| odd_par_i | input | 1 | Parity mode: 0 even, 1 odd |
| rx_done_i | input | 1 | One-cycle pulse: a character has been received |
| rx_data_i | input | DATA_W | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| tx_take_i | input | 1 | One-cycle pulse: transmit data moved into the shifter |
| tx_last_i | input | 1 | One-cycle pulse: last bit of a character sent |
| rd_en_i | input | 1 | Status register read |
| wr_en_i | input | 1 | Status register write |
| wr_data_i | input | STAT_W | Status write data |
| rd_data_o | output | STAT_W | Status read data |
| tdre_o | output | 1 | Transmit data empty flag |
| rdrf_o | output | 1 | Receive data full flag |
| per_o | output | 1 | Receive parity error flag |
| tend_o | output | 1 | Transmit end flag |
| rdr_load_o | output | 1 | Load strobe for the receive data register |
| rx_halt_o | output | 1 | Reception halted by a pending parity error |

## Verification
A flag's set event can coincide with the software write that completes its two-step clear. Likewise, a last-bit event can coincide with the clear of transmit empty that would otherwise drop transmit end. The bench arms the clear with a read. It then drives the clearing write in the same cycle as the transfer-taken pulse, and in a second case in the same cycle as the last-bit pulse. After that edge it checks that transmit empty stays 1 in the first case. In the second case transmit empty falls while transmit end stays 1.

// File: rtl/uart_flag_pkg.sv
// Shared constants for the serial status flag controller.
// Assumes status bit positions are fixed by software convention.
package uart_flag_pkg;
    localparam int STAT_W = 4;
    localparam int NCELL  = 3;    // writable-by-clear flags held in generic cells
    localparam int B_TDRE = 0;
    localparam int B_RDRF = 1;
    localparam int B_PER  = 2;
    localparam int B_TEND = 3;
endpackage

// File: rtl/flag_cell.sv
// One status flag with the two-step clear rule: a read that sees the flag
// at 1 arms it, and a later write of 0 clears it. Any write disarms.
// A set event beats a same-cycle clear. force_i returns it to INIT.
// Assumes rd_i/wr_i are single-cycle strobes from the register port.
module flag_cell #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wr_bit_i,
    output logic flag_o,
    output logic clr_o
);
    logic flag_q;
    logic arm_q;
    logic clr_req;

    assign clr_req = wr_i && !wr_bit_i && arm_q;
    assign clr_o   = clr_req && !set_i && !force_i;
    assign flag_o  = flag_q;

    // Flag register: force, then set, then qualified clear.
    always_ff @(posedge clk) begin
        if (!rst_n || force_i)  flag_q <= INIT;
        else if (set_i)         flag_q <= 1'b1;
        else if (clr_req)       flag_q <= 1'b0;
    end

    // Arm latch: remembers a read that observed the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n || force_i)   arm_q <= 1'b0;
        else if (wr_i)           arm_q <= 1'b0;
        else if (rd_i && flag_q) arm_q <= 1'b1;
    end

    // R2
    clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> ($past(force_i) || $past(arm_q && wr_i && !wr_bit_i)));

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !force_i) |=> flag_q);
endmodule

// File: rtl/rx_check.sv
// Receive acceptance and parity judgement for one character event.
// Assumes rx_done_i is a single-cycle pulse with data and parity valid.
module rx_check #(
    parameter int DATA_W = 8
) (
    input  logic              rx_done_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_par_i,
    input  logic              odd_par_i,
    input  logic              re_i,
    input  logic              per_i,
    input  logic              standby_i,
    output logic              load_o,
    output logic              good_o,
    output logic              bad_o
);
    logic accept;
    logic mismatch;

    // Acceptance and parity decision for the current event.
    always_comb begin
        accept   = rx_done_i && re_i && !per_i && !standby_i;
        mismatch = ((^rx_data_i) ^ rx_par_i) != odd_par_i;
        load_o   = accept;
        good_o   = accept && !mismatch;
        bad_o    = accept && mismatch;
    end
endmodule

// File: rtl/tend_ctrl.sv
// Transmit-end flag: set by a last-bit event while transmit empty is 1,
// cleared by a completed two-step clear of transmit empty, and forced to 1
// while transmit is disabled, in standby or in reset. Read-only for software.
module tend_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic te_i,
    input  logic standby_i,
    input  logic last_i,
    input  logic tdre_i,
    input  logic tdre_clr_i,
    output logic tend_o
);
    logic tend_q;
    logic set_ev;

    assign set_ev = last_i && tdre_i;
    assign tend_o = tend_q;

    // Flag register: force high, then set, then clear with transmit empty.
    always_ff @(posedge clk) begin
        if (!rst_n || !te_i || standby_i) tend_q <= 1'b1;
        else if (set_ev)                  tend_q <= 1'b1;
        else if (tdre_clr_i)              tend_q <= 1'b0;
    end

    // R8
    te_off_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !te_i |=> tend_q);

    // R6
    last_bit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (te_i && last_i && tdre_i) |=> tend_q);
endmodule

// File: rtl/uart_flag_ctrl.sv
// Top of the serial status flag controller. Builds the three clearable flags
// from flag_cell, judges received characters in rx_check and derives
// transmit end in tend_ctrl. Assumes all event inputs are one-cycle pulses
// synchronous to clk.
module uart_flag_ctrl
    import uart_flag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              te_i,
    input  logic              re_i,
    input  logic              odd_par_i,
    input  logic              rx_done_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              rx_par_i,
    input  logic              tx_take_i,
    input  logic              tx_last_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] rd_data_o,
    output logic              tdre_o,
    output logic              rdrf_o,
    output logic              per_o,
    output logic              tend_o,
    output logic              rdr_load_o,
    output logic              rx_halt_o
);
    logic [NCELL-1:0] set_v;
    logic [NCELL-1:0] flag_v;
    logic [NCELL-1:0] clr_v;
    logic             rx_good;
    logic             rx_bad;
    logic             tend_w;

    rx_check #(.DATA_W(DATA_W)) u_rx (
        .rx_done_i (rx_done_i),
        .rx_data_i (rx_data_i),
        .rx_par_i  (rx_par_i),
        .odd_par_i (odd_par_i),
        .re_i      (re_i),
        .per_i     (flag_v[B_PER]),
        .standby_i (standby_i),
        .load_o    (rdr_load_o),
        .good_o    (rx_good),
        .bad_o     (rx_bad)
    );

    // Set-event routing to the clearable flag cells.
    always_comb begin
        set_v         = '0;
        set_v[B_TDRE] = tx_take_i;
        set_v[B_RDRF] = rx_good;
        set_v[B_PER]  = rx_bad;
    end

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        flag_cell #(.INIT(i == B_TDRE)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .force_i  (standby_i),
            .set_i    (set_v[i]),
            .rd_i     (rd_en_i),
            .wr_i     (wr_en_i),
            .wr_bit_i (wr_data_i[i]),
            .flag_o   (flag_v[i]),
            .clr_o    (clr_v[i])
        );
    end

    tend_ctrl u_tend (
        .clk        (clk),
        .rst_n      (rst_n),
        .te_i       (te_i),
        .standby_i  (standby_i),
        .last_i     (tx_last_i),
        .tdre_i     (flag_v[B_TDRE]),
        .tdre_clr_i (clr_v[B_TDRE]),
        .tend_o     (tend_w)
    );

    // Output mapping and status read image.
    always_comb begin
        tdre_o    = flag_v[B_TDRE];
        rdrf_o    = flag_v[B_RDRF];
        per_o     = flag_v[B_PER];
        tend_o    = tend_w;
        rx_halt_o = flag_v[B_PER];
        rd_data_o = {tend_w, flag_v[B_PER], flag_v[B_RDRF], flag_v[B_TDRE]};
    end

    // R5
    halt_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_o |-> !rdr_load_o);

    // R4
    bad_char_no_rdrf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_bad && !standby_i) |=> (per_o && !$rose(rdrf_o)));

    // R9
    tend_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_data_i[B_TEND] && tend_o && te_i && !clr_v[B_TDRE]) |=> tend_o);
endmodule

// File: tb/sim_uart_flag_ctrl.sv
module sim_uart_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby_i = 1'b0, te_i = 1'b0, re_i = 1'b0, odd_par_i = 1'b0;
    logic       rx_done_i = 1'b0, rx_par_i = 1'b0, tx_take_i = 1'b0, tx_last_i = 1'b0;
    logic [7:0] rx_data_i = '0;
    logic       rd_en_i = 1'b0, wr_en_i = 1'b0;
    logic [3:0] wr_data_i = '0;
    logic [3:0] rd_data_o;
    logic       tdre_o, rdrf_o, per_o, tend_o, rdr_load_o, rx_halt_o;
    int total = 0;
    int bad = 0;
    logic fin = 1'b0;

    always #10 clk = ~clk;

    uart_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .te_i(te_i), .re_i(re_i),
        .odd_par_i(odd_par_i), .rx_done_i(rx_done_i), .rx_data_i(rx_data_i),
        .rx_par_i(rx_par_i), .tx_take_i(tx_take_i), .tx_last_i(tx_last_i),
        .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .tdre_o(tdre_o), .rdrf_o(rdrf_o), .per_o(per_o),
        .tend_o(tend_o), .rdr_load_o(rdr_load_o), .rx_halt_o(rx_halt_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic cpu_read();
        rd_en_i = 1'b1; step(); rd_en_i = 1'b0;
    endtask

    task automatic cpu_write(input logic [3:0] d);
        wr_en_i = 1'b1; wr_data_i = d; step(); wr_en_i = 1'b0;
    endtask

    // Drives one received character; checks the load strobe in its cycle.
    task automatic rx_char(input logic [7:0] d, input logic p, input logic exp_load, input string tag);
        rx_done_i = 1'b1; rx_data_i = d; rx_par_i = p;
        #2 chk(tag, rdr_load_o, exp_load);
        step(); rx_done_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 status", rd_data_o, 8'h9);
        chk("R11 halt", rx_halt_o, 1'b0);
    endtask

    task automatic t_rx_good();
        re_i = 1'b1; odd_par_i = 1'b0;
        rx_char(8'hA5, 1'b0, 1'b1, "R12 even load");
        chk("R12 rdrf set", rdrf_o, 1'b1);
        chk("R1 no per even", per_o, 1'b0);
        cpu_read(); cpu_write(4'b1101);
        chk("R2 rdrf cleared", rdrf_o, 1'b0);
        odd_par_i = 1'b1;
        rx_char(8'h01, 1'b0, 1'b1, "R12 odd load");
        chk("R1 no per odd", per_o, 1'b0);
        chk("R12 rdrf odd", rdrf_o, 1'b1);
        cpu_read(); cpu_write(4'b1101);
        re_i = 1'b0;
        rx_char(8'hA5, 1'b0, 1'b0, "R12 re off no load");
        chk("R12 re off rdrf", rdrf_o, 1'b0);
    endtask

    task automatic t_rx_bad();
        re_i = 1'b1; odd_par_i = 1'b0;
        rx_char(8'h03, 1'b1, 1'b1, "R4 bad load");
        chk("R1 per even err", per_o, 1'b1);
        chk("R4 rdrf not set", rdrf_o, 1'b0);
        chk("R5 halt", rx_halt_o, 1'b1);
        rx_char(8'hA5, 1'b0, 1'b0, "R5 no load while halted");
        chk("R5 rdrf held", rdrf_o, 1'b0);
        re_i = 1'b0; step(); step();
        chk("R3 per kept", per_o, 1'b1);
        re_i = 1'b1;
    endtask

    task automatic t_per_clear();
        cpu_write(4'b1011);
        chk("R2 write0 no read", per_o, 1'b1);
        cpu_read(); cpu_write(4'b1111);
        chk("R2 write1 ignored", per_o, 1'b1);
        cpu_read(); cpu_write(4'b1011);
        chk("R2 per cleared", per_o, 1'b0);
        chk("R5 halt released", rx_halt_o, 1'b0);
    endtask

    task automatic t_standby();
        odd_par_i = 1'b1;
        rx_char(8'h03, 1'b0, 1'b1, "R1 odd err load");
        chk("R1 per odd err", per_o, 1'b1);
        te_i = 1'b1; cpu_read(); cpu_write(4'b1110);
        chk("R7 tdre cleared", tdre_o, 1'b0);
        standby_i = 1'b1; step(); standby_i = 1'b0;
        chk("R13 standby status", rd_data_o, 8'h9);
    endtask

    task automatic t_tend();
        te_i = 1'b1;
        cpu_read(); cpu_write(4'b1110);
        chk("R7 tend cleared", tend_o, 1'b0);
        tx_last_i = 1'b1; step(); tx_last_i = 1'b0;
        chk("R6 no set tdre0", tend_o, 1'b0);
        tx_take_i = 1'b1; step(); tx_take_i = 1'b0;
        chk("R6 tdre back", tdre_o, 1'b1);
        tx_last_i = 1'b1; step(); tx_last_i = 1'b0;
        chk("R6 tend set", tend_o, 1'b1);
        cpu_write(4'b0111);
        chk("R9 write no read", tend_o, 1'b1);
        cpu_read(); cpu_write(4'b0111);
        chk("R9 write after read", tend_o, 1'b1);
        cpu_read(); cpu_write(4'b1110);
        chk("R7 tend cleared again", tend_o, 1'b0);
        te_i = 1'b0; step();
        chk("R8 te off forces", tend_o, 1'b1);
        te_i = 1'b1;
        tx_take_i = 1'b1; step(); tx_take_i = 1'b0;
    endtask

    task automatic t_set_wins();
        te_i = 1'b1;
        cpu_read();
        tx_take_i = 1'b1; cpu_write(4'b1110); tx_take_i = 1'b0;
        chk("R10 tdre set wins", tdre_o, 1'b1);
        chk("R10 tend kept", tend_o, 1'b1);
        cpu_read();
        tx_last_i = 1'b1; cpu_write(4'b1110); tx_last_i = 1'b0;
        chk("R10 tdre cleared", tdre_o, 1'b0);
        chk("R10 tend set wins", tend_o, 1'b1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_rx_good();
        t_rx_bad();
        t_per_clear();
        t_standby();
        t_tend();
        t_set_wins();
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!fin) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule